// File: doc/BRIEF.md
# Tile Buffer Flush Sequencer

This block sequences one 16x16 tile of a tile-local rasteriser through its life. The tile is 256 pixels, held in an on-chip colour RAM and an on-chip depth RAM that live inside the block. After a start request the block fills the tile in one of two ways. It either clears both RAMs to fixed constants or reloads them from an external staging memory under a ready handshake. It then hands the tile to an external render stage, which writes pixels through a write port while the block waits for a done pulse. Depth tests are the render stage's job.

When the render stage is done, the tile leaves the block in two consecutive passes. The colour pass emits one address/data pair per pixel, and the depth pass then does the same for depth. Both passes use the same screen-linear word address: the tile origin and the framebuffer width are captured when the start request is accepted. The busy output stays high until the depth pass has emitted its last pixel, so the surrounding logic can use its falling edge as the "tile fully written back" event.

Top module: `tile_flush_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o is 0, phase_o is 0 (idle), render_go_o is 0 and neither emit output is high.
- R2: A start_i pulse accepted in idle with reload_mode_i=0 moves phase_o to 1 (clear) on the next cycle. The clear sets every one of the 256 colour entries to 0xFF008000 and every depth entry to 0x00004000.
- R3: After the fill, phase_o is 2 (render) and render_go_o is high. Render-port writes (separate colour and depth enables) land in the tile only in this phase. A render_done_i pulse moves phase_o to 3.
- R4: The colour pass has phase code 3 and gives exactly 256 cflush_emit_o pulses on consecutive cycles. Pixel indices run 0 to 255 in ascending order, and the first emit comes one cycle after phase_o first reads 3.
- R5: Phase 6 (depth pass) is entered only straight from phase 3. It gives exactly 256 zflush_emit_o pulses with indices 0 to 255 in ascending order, the first one cycle after phase_o first reads 6. A depth emit never occurs before all 256 colour emits, and the two emits are never high together.
- R6: For pixel index i, with x = i & 15 and y = i >> 4, the emitted address is ((oy + y) * fbw * 64 + (ox + x)) * 4. Here ox, oy and fbw are tile_ox_i, tile_oy_i and fbw_i, sampled when start is accepted.
- R7: Emitted colour and depth data equal the full 32-bit tile RAM word for that pixel at flush time, without truncation or byte reordering.
- R8: busy_o is high from the cycle after start is accepted until the depth pass ends. It falls only out of phase 6, after which phase_o reads 0.
- R9: With reload_mode_i=1 the block enters phase 4 and pulses stage_start_o for exactly one cycle, in the first phase-4 cycle. stage_raddr_o then steps 0 to 255. The block stores stage_color_i and stage_depth_i at stage_raddr_o, and advances, only in cycles where stage_ready_i is high.
- R10: start_i is ignored while busy_o is high. Render-port writes outside phase 2 do not change the tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only in idle |
| reload_mode_i | input | 1 | 1: fill from staging, 0: clear |
| tile_ox_i | input | 12 | Tile origin x in pixels |
| tile_oy_i | input | 12 | Tile origin y in pixels |
| fbw_i | input | 6 | Framebuffer width in units of 64 pixels |
| busy_o | output | 1 | High from start until depth pass ends |
| phase_o | output | 3 | Current phase code |
| render_go_o | output | 1 | Render stage owns the tile |
| render_done_i | input | 1 | Render stage finished |
| rw_color_we_i | input | 1 | Render colour write enable |
| rw_depth_we_i | input | 1 | Render depth write enable |
| rw_idx_i | input | 8 | Render write pixel index |
| rw_color_i | input | 32 | Render colour word |
| rw_depth_i | input | 32 | Render depth word |
| stage_start_o | output | 1 | One-cycle reload start strobe |
| stage_raddr_o | output | 8 | Staging read index |
| stage_ready_i | input | 1 | Staging data valid |
| stage_color_i | input | 32 | Staging colour word |
| stage_depth_i | input | 32 | Staging depth word |
| cflush_emit_o | output | 1 | Colour flush word valid |
| cflush_addr_o | output | 32 | Colour flush byte address |
| cflush_data_o | output | 32 | Colour flush word |
| zflush_emit_o | output | 1 | Depth flush word valid |
| zflush_addr_o | output | 32 | Depth flush byte address |
| zflush_data_o | output | 32 | Depth flush word |

## Verification
A start accepted at one edge shows as busy and the new phase code one cycle later, and a render_done pulse likewise shows phase 3 one cycle later. Each pass's first emit is due exactly one cycle after its phase code first appears, because the RAM read takes one registered cycle. The bench records the cycle in which each phase code first appears, then checks every emit on the falling edge against a tile model and an address it computes itself. The reload handshake is checked on every ready cycle against a running index.

// File: rtl/tfs_pkg.sv
// Shared phase encoding for the tile flush sequencer.
// Codes 3 and 6 are fixed because downstream logic decodes them.
package tfs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_CLEAR  = 3'd1,
        PH_RENDER = 3'd2,
        PH_CFLUSH = 3'd3,
        PH_RELOAD = 3'd4,
        PH_ZFLUSH = 3'd6
    } phase_e;
endpackage

// File: rtl/tfs_tile_ram.sv
// One channel of tile storage: a single write port and one registered
// read port (one cycle of read latency). No reset on contents; the
// sequencer always fills the tile before reading it.
module tfs_tile_ram #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write port and registered read port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tfs_screen_addr.sv
// Maps a tile pixel index to a framebuffer byte address for 32-bit words.
// Assumes the framebuffer row stride is fbw * 64 pixels.
module tfs_screen_addr #(
    parameter int TW      = 4,
    parameter int COORD_W = 12,
    parameter int FBW_W   = 6,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = 2 * TW
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [COORD_W-1:0] ox,
    input  logic [COORD_W-1:0] oy,
    input  logic [FBW_W-1:0]   fbw,
    output logic [ADDR_W-1:0]  addr
);
    logic [ADDR_W-1:0] row, col, stride, lin;

    // Row/column split of the index and linearisation.
    always_comb begin
        row    = ADDR_W'(oy) + ADDR_W'(idx[IDX_W-1:TW]);
        col    = ADDR_W'(ox) + ADDR_W'(idx[TW-1:0]);
        stride = ADDR_W'(fbw) << 6;
        lin    = row * stride + col;
        addr   = lin << 2;
    end
endmodule

// File: rtl/tile_flush_seq.sv
// Tile phase sequencer: fill (clear or staged reload), render hand-off,
// colour flush, then depth flush. Owns both tile RAMs.
// Assumes: staging data is valid in the cycle stage_ready_i is high for
// the address on stage_raddr_o; origin and width are sampled at start.
module tile_flush_seq
    import tfs_pkg::*;
#(
    parameter int          TILE_DIM    = 16,
    parameter int          DATA_W      = 32,
    parameter int          COORD_W     = 12,
    parameter int          FBW_W       = 6,
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] CLEAR_COLOR = 32'hFF00_8000,
    parameter logic [31:0] CLEAR_DEPTH = 32'h0000_4000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               reload_mode_i,
    input  logic [COORD_W-1:0] tile_ox_i,
    input  logic [COORD_W-1:0] tile_oy_i,
    input  logic [FBW_W-1:0]   fbw_i,
    output logic               busy_o,
    output logic [2:0]         phase_o,
    output logic               render_go_o,
    input  logic               render_done_i,
    input  logic               rw_color_we_i,
    input  logic               rw_depth_we_i,
    input  logic [2*$clog2(TILE_DIM)-1:0] rw_idx_i,
    input  logic [DATA_W-1:0]  rw_color_i,
    input  logic [DATA_W-1:0]  rw_depth_i,
    output logic               stage_start_o,
    output logic [2*$clog2(TILE_DIM)-1:0] stage_raddr_o,
    input  logic               stage_ready_i,
    input  logic [DATA_W-1:0]  stage_color_i,
    input  logic [DATA_W-1:0]  stage_depth_i,
    output logic               cflush_emit_o,
    output logic [ADDR_W-1:0]  cflush_addr_o,
    output logic [DATA_W-1:0]  cflush_data_o,
    output logic               zflush_emit_o,
    output logic [ADDR_W-1:0]  zflush_addr_o,
    output logic [DATA_W-1:0]  zflush_data_o
);
    localparam int TW    = $clog2(TILE_DIM);
    localparam int IDX_W = 2 * TW;
    localparam int NPIX  = TILE_DIM * TILE_DIM;
    localparam int CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NPIX - 1);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(NPIX);
    localparam int NCH   = 2;   // channel 0 colour, channel 1 depth

    phase_e             phase_q, phase_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [COORD_W-1:0] ox_q, oy_q;
    logic [FBW_W-1:0]   fbw_q;
    logic               start_ok, cnt_last, flush_done, rd_issue;
    logic               v_q, zsel_q, stg_pulse_q;
    logic [IDX_W-1:0]   idx_q;
    logic [ADDR_W-1:0]  emit_addr;

    logic [NCH-1:0]             ch_we;
    logic [IDX_W-1:0]           ch_waddr;
    logic [NCH-1:0][DATA_W-1:0] ch_wdata, ch_rdata;

    assign start_ok   = (phase_q == PH_IDLE) && start_i;
    assign cnt_last   = (cnt_q == LAST);
    assign flush_done = (cnt_q == DONE);
    assign rd_issue   = ((phase_q == PH_CFLUSH) || (phase_q == PH_ZFLUSH)) && !flush_done;

    // Next-phase and index-counter selection.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                cnt_d = '0;
                if (start_i) phase_d = reload_mode_i ? PH_RELOAD : PH_CLEAR;
            end
            PH_CLEAR: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_last) begin phase_d = PH_RENDER; cnt_d = '0; end
            end
            PH_RELOAD: begin
                if (stage_ready_i) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_last) begin phase_d = PH_RENDER; cnt_d = '0; end
                end
            end
            PH_RENDER: begin
                cnt_d = '0;
                if (render_done_i) phase_d = PH_CFLUSH;
            end
            PH_CFLUSH: begin
                cnt_d = cnt_q + 1'b1;
                if (flush_done) begin phase_d = PH_ZFLUSH; cnt_d = '0; end
            end
            PH_ZFLUSH: begin
                cnt_d = cnt_q + 1'b1;
                if (flush_done) begin phase_d = PH_IDLE; cnt_d = '0; end
            end
            default: begin phase_d = PH_IDLE; cnt_d = '0; end
        endcase
    end

    // Phase, counter and sampled tile geometry registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            ox_q        <= '0;
            oy_q        <= '0;
            fbw_q       <= '0;
            stg_pulse_q <= 1'b0;
        end else begin
            phase_q     <= phase_d;
            cnt_q       <= cnt_d;
            stg_pulse_q <= start_ok && reload_mode_i;
            if (start_ok) begin
                ox_q  <= tile_ox_i;
                oy_q  <= tile_oy_i;
                fbw_q <= fbw_i;
            end
        end
    end

    // Read pipeline: emit is valid one cycle after the read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            zsel_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            v_q    <= rd_issue;
            zsel_q <= (phase_q == PH_ZFLUSH);
            idx_q  <= cnt_q[IDX_W-1:0];
        end
    end

    // Write-port source selection for both tile channels.
    always_comb begin
        ch_waddr    = (phase_q == PH_RENDER) ? rw_idx_i : cnt_q[IDX_W-1:0];
        ch_we       = '0;
        ch_wdata[0] = rw_color_i;
        ch_wdata[1] = rw_depth_i;
        unique case (phase_q)
            PH_CLEAR: begin
                ch_we       = '1;
                ch_wdata[0] = CLEAR_COLOR;
                ch_wdata[1] = CLEAR_DEPTH;
            end
            PH_RELOAD: begin
                ch_we       = {NCH{stage_ready_i}};
                ch_wdata[0] = stage_color_i;
                ch_wdata[1] = stage_depth_i;
            end
            PH_RENDER: ch_we = {rw_depth_we_i, rw_color_we_i};
            default:   ch_we = '0;
        endcase
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        tfs_tile_ram #(.DEPTH(NPIX), .DATA_W(DATA_W)) i_ram (
            .clk   (clk),
            .we    (ch_we[ch]),
            .waddr (ch_waddr),
            .wdata (ch_wdata[ch]),
            .raddr (cnt_q[IDX_W-1:0]),
            .rdata (ch_rdata[ch])
        );
    end

    tfs_screen_addr #(.TW(TW), .COORD_W(COORD_W), .FBW_W(FBW_W), .ADDR_W(ADDR_W)) i_addr (
        .idx  (idx_q),
        .ox   (ox_q),
        .oy   (oy_q),
        .fbw  (fbw_q),
        .addr (emit_addr)
    );

    assign busy_o        = (phase_q != PH_IDLE);
    assign phase_o       = phase_q;
    assign render_go_o   = (phase_q == PH_RENDER);
    assign stage_start_o = stg_pulse_q;
    assign stage_raddr_o = cnt_q[IDX_W-1:0];
    assign cflush_emit_o = v_q && !zsel_q;
    assign zflush_emit_o = v_q && zsel_q;
    assign cflush_addr_o = emit_addr;
    assign zflush_addr_o = emit_addr;
    assign cflush_data_o = ch_rdata[0];
    assign zflush_data_o = ch_rdata[1];

    // Depth pass may only be entered from the colour pass.
    p_zflush_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_CFLUSH && phase_q != PH_ZFLUSH) |=> (phase_q != PH_ZFLUSH));

    // Colour and depth emits are mutually exclusive.
    p_single_emit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cflush_emit_o && zflush_emit_o));

    // Any emit is backed by a read issued the cycle before.
    p_emit_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cflush_emit_o || zflush_emit_o) |-> $past(rd_issue));

    // Busy only drops out of the depth pass.
    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(phase_q) == PH_ZFLUSH));

    // Reload index holds while staging is not ready.
    p_reload_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RELOAD && !stage_ready_i) |=> $stable(cnt_q));

    // A start request cannot cut a tile short.
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && phase_q != PH_ZFLUSH) |=> busy_o);
endmodule

// File: tb/test_tile_flush_seq.sv
`timescale 1ns/1ps
module test_tile_flush_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, reload_mode_i, render_done_i;
    logic [11:0] tile_ox_i, tile_oy_i;
    logic [5:0]  fbw_i;
    logic        busy_o, render_go_o, stage_start_o, stage_ready_i;
    logic [2:0]  phase_o;
    logic        rw_color_we_i, rw_depth_we_i;
    logic [7:0]  rw_idx_i, stage_raddr_o;
    logic [31:0] rw_color_i, rw_depth_i, stage_color_i, stage_depth_i;
    logic        cflush_emit_o, zflush_emit_o;
    logic [31:0] cflush_addr_o, cflush_data_o, zflush_addr_o, zflush_data_o;

    always #4 clk = ~clk;   // 125 MHz

    int cur_seed;

    function automatic logic [31:0] stg_c(input logic [7:0] a, input int s);
        return {8'h5A, 8'(s), 8'h00, a};
    endfunction
    function automatic logic [31:0] stg_d(input logic [7:0] a, input int s);
        return 32'h0000_1000 + 32'(a) * 5 + 32'(s);
    endfunction

    assign stage_color_i = stg_c(stage_raddr_o, cur_seed);
    assign stage_depth_i = stg_d(stage_raddr_o, cur_seed);

    tile_flush_seq i_tile_flush_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reload_mode_i(reload_mode_i),
        .tile_ox_i(tile_ox_i), .tile_oy_i(tile_oy_i), .fbw_i(fbw_i),
        .busy_o(busy_o), .phase_o(phase_o), .render_go_o(render_go_o),
        .render_done_i(render_done_i), .rw_color_we_i(rw_color_we_i),
        .rw_depth_we_i(rw_depth_we_i), .rw_idx_i(rw_idx_i), .rw_color_i(rw_color_i),
        .rw_depth_i(rw_depth_i), .stage_start_o(stage_start_o),
        .stage_raddr_o(stage_raddr_o), .stage_ready_i(stage_ready_i),
        .stage_color_i(stage_color_i), .stage_depth_i(stage_depth_i),
        .cflush_emit_o(cflush_emit_o), .cflush_addr_o(cflush_addr_o),
        .cflush_data_o(cflush_data_o), .zflush_emit_o(zflush_emit_o),
        .zflush_addr_o(zflush_addr_o), .zflush_data_o(zflush_data_o)
    );

    int nchk = 0, nerr = 0;
    int cyc = 0;
    logic [31:0] exp_c [256];
    logic [31:0] exp_z [256];
    logic [11:0] m_ox, m_oy;
    logic [5:0]  m_fbw;
    int cidx, zidx, pulses, rl_idx, c_entry, z_entry;
    logic [2:0] ph_prev;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input int i);
        logic [31:0] row, col;
        row = 32'(m_oy) + 32'(i / 16);
        col = 32'(m_ox) + 32'(i % 16);
        return (row * (32'(m_fbw) * 64) + col) * 4;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    // Staging ready pattern: low one cycle in three.
    initial begin
        stage_ready_i = 1'b0;
        forever begin
            @(negedge clk);
            stage_ready_i = (cyc % 3) != 0;
        end
    end

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (phase_o == 3'd3 && ph_prev != 3'd3) c_entry = cyc;
            if (phase_o == 3'd6 && ph_prev != 3'd6) begin
                z_entry = cyc;
                check(ph_prev == 3'd3, "R5 depth pass entry", 32'(ph_prev), 32'd3);
            end
            if (cflush_emit_o) begin
                if (cidx == 0) check(cyc == c_entry + 1, "R4 first colour emit cycle", cyc, c_entry + 1);
                check(cidx < 256, "R4 colour emit count", cidx, 255);
                check(phase_o == 3'd3, "R4 phase during colour emit", 32'(phase_o), 32'd3);
                if (cidx < 256) begin
                    check(cflush_addr_o == exp_addr(cidx), "R6 colour addr", cflush_addr_o, exp_addr(cidx));
                    check(cflush_data_o === exp_c[cidx], "R7 colour data", cflush_data_o, exp_c[cidx]);
                end
                cidx++;
            end
            if (zflush_emit_o) begin
                check(cidx == 256, "R5 depth before colour done", cidx, 256);
                if (zidx == 0) check(cyc == z_entry + 1, "R5 first depth emit cycle", cyc, z_entry + 1);
                check(zidx < 256, "R5 depth emit count", zidx, 255);
                check(phase_o == 3'd6, "R5 phase during depth emit", 32'(phase_o), 32'd6);
                if (zidx < 256) begin
                    check(zflush_addr_o == exp_addr(zidx), "R6 depth addr", zflush_addr_o, exp_addr(zidx));
                    check(zflush_data_o === exp_z[zidx], "R7 depth data", zflush_data_o, exp_z[zidx]);
                end
                zidx++;
            end
            if (stage_start_o) begin
                pulses++;
                check(phase_o == 3'd4, "R9 strobe phase", 32'(phase_o), 32'd4);
            end
            if (phase_o == 3'd4 && stage_ready_i) begin
                check(stage_raddr_o == 8'(rl_idx), "R9 staging index", 32'(stage_raddr_o), rl_idx);
                rl_idx++;
            end
            ph_prev = phase_o;
        end
    end

    task automatic run_tile(input bit rl, input logic [11:0] ox, input logic [11:0] oy,
                            input logic [5:0] fbw, input int seed);
        cur_seed = seed;
        m_ox = ox; m_oy = oy; m_fbw = fbw;
        for (int i = 0; i < 256; i++) begin
            exp_c[i] = rl ? stg_c(8'(i), seed) : 32'hFF00_8000;
            exp_z[i] = rl ? stg_d(8'(i), seed) : 32'h0000_4000;
        end
        cidx = 0; zidx = 0; pulses = 0; rl_idx = 0;
        @(negedge clk);
        start_i = 1'b1; reload_mode_i = rl;
        tile_ox_i = ox; tile_oy_i = oy; fbw_i = fbw;
        @(negedge clk);
        start_i = 1'b0;
        tile_ox_i = 12'hABC; tile_oy_i = 12'h123; fbw_i = 6'd9;  // R6: must not matter now
        check(busy_o == 1'b1, "R8 busy after start", 32'(busy_o), 32'd1);
        check(phase_o == (rl ? 3'd4 : 3'd1), "R2 R9 fill phase", 32'(phase_o), rl ? 32'd4 : 32'd1);
        // R10: render-port write during fill is discarded (clear/reload overwrite is the
        // expected content; a write after the fill index passes is caught by the flush data).
        while (phase_o != 3'd2) @(negedge clk);
        check(render_go_o == 1'b1, "R3 render_go in render phase", 32'(render_go_o), 32'd1);
        start_i = 1'b1;                 // R10: ignored while busy
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 256; i++) begin
            if ((i * 7 + seed) % 5 == 0) begin
                rw_idx_i      = 8'(i);
                rw_color_i    = {8'(seed), 8'h11, 8'(i), 8'(i ^ 8'h3C)};
                rw_depth_i    = 32'h0100_0000 * 32'(seed) + 32'(i) * 3;
                rw_color_we_i = ((i + seed) % 3) != 1;
                rw_depth_we_i = ((i + seed) % 3) != 2;
                if (rw_color_we_i) exp_c[i] = rw_color_i;
                if (rw_depth_we_i) exp_z[i] = rw_depth_i;
                @(negedge clk);
            end
        end
        rw_color_we_i = 1'b0; rw_depth_we_i = 1'b0;
        render_done_i = 1'b1;
        @(negedge clk);
        render_done_i = 1'b0;
        check(phase_o == 3'd3, "R3 done enters colour pass", 32'(phase_o), 32'd3);
        // R10: write during the colour pass must not reach the tile (index 250 read later).
        repeat (5) @(negedge clk);
        rw_idx_i = 8'd250; rw_color_i = 32'hDEAD_BEEF; rw_depth_i = 32'hBAD0_0BAD;
        rw_color_we_i = 1'b1; rw_depth_we_i = 1'b1;
        @(negedge clk);
        rw_color_we_i = 1'b0; rw_depth_we_i = 1'b0;
        while (busy_o) @(negedge clk);
        check(phase_o == 3'd0, "R8 idle after depth pass", 32'(phase_o), 32'd0);
        check(cidx == 256, "R4 total colour emits", cidx, 256);
        check(zidx == 256, "R5 total depth emits", zidx, 256);
        check(pulses == (rl ? 1 : 0), "R9 strobe count", pulses, rl ? 1 : 0);
        if (rl) check(rl_idx == 256, "R9 staged words", rl_idx, 256);
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0, "R10 no restart from ignored start", 32'(busy_o), 32'd0);
    endtask

    initial begin
        ph_prev = 3'd0; c_entry = -10; z_entry = -10;
        cidx = 0; zidx = 0; pulses = 0; rl_idx = 0; cur_seed = 0;
        rst_n = 1'b0; start_i = 1'b0; reload_mode_i = 1'b0; render_done_i = 1'b0;
        tile_ox_i = '0; tile_oy_i = '0; fbw_i = 6'd1;
        rw_color_we_i = 1'b0; rw_depth_we_i = 1'b0; rw_idx_i = '0;
        rw_color_i = '0; rw_depth_i = '0;
        repeat (4) @(negedge clk);
        check(busy_o == 1'b0 && phase_o == 3'd0, "R1 reset idle", {29'd0, phase_o}, 32'd0);
        check(!cflush_emit_o && !zflush_emit_o && !render_go_o, "R1 reset outputs quiet",
              {29'd0, cflush_emit_o, zflush_emit_o, render_go_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0, "R1 idle after reset", 32'(busy_o), 32'd0);
        run_tile(1'b0, 12'd0,    12'd0,    6'd1,  1);
        run_tile(1'b0, 12'd16,   12'd32,   6'd2,  2);
        run_tile(1'b1, 12'd48,   12'd16,   6'd3,  3);
        run_tile(1'b0, 12'd4080, 12'd4064, 6'd63, 4);
        run_tile(1'b1, 12'd0,    12'd240,  6'd4,  5);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule